// File: doc/BRIEF.md
# Edge-Qualified DMA Request Sequencer

This block is the request front end and sequencer for one DMA channel that moves data in blocks. An external active-low request pin asks for service. The block passes the pin through a synchronizer and samples it on every clock. While acceptance is open, a low sample latches a pending request, and that request is presented to the bus arbiter. When the arbiter signals a bus-break slot, the block drops the pending flag and runs one block. A block is a number of read/write strobe pairs followed by a single dead cycle. The block then hands the bus back.

A level that simply stays low cannot start a second block. After each activation the block closes acceptance. It opens again only when the synchronized pin has been seen high and the dead cycle has finished. If no high level has been seen by the end of the dead cycle, acceptance stays closed until a high sample arrives, and it opens on the cycle after that sample.

A write to the channel enable loads the number of blocks to run. The channel disables itself after the last block. Address generation and data movement belong to other logic; this block produces only the phase strobes.

Top module: `dreq_block_seq`

## Requirements
- R1: A synchronous active-low reset leaves every output low and acceptance closed.
- R2: A pulse on `en_wr` while `chan_en` is low sets `chan_en` on the next cycle, opens acceptance and loads the block count from `xfer_cnt`. A pulse on `en_wr` while `chan_en` is high has no effect.
- R3: The pin passes through two synchronizer flops before the pending flag. With acceptance open, a low level first driven in the cycle before clock edge k raises `bus_req` in the cycle after edge k+2.
- R4: A pending request is held, and `bus_req` stays high, for as long as no `bus_brk` arrives while the sequencer is idle.
- R5: If `bus_brk` is high in an idle cycle with a pending request, the pending flag clears on that edge and `rd_stb` is high in the next cycle.
- R6: Each block issues N read/write pairs. N is `blk_len` captured at activation, with 0 treated as 1. Each `rd_stb` cycle is followed by one `wr_stb` cycle, and the block always starts with a read.
- R7: Exactly one `dead_cyc` cycle follows the last write of a block. `bus_req` is high from the pending request through the dead cycle and is low in the cycle after it.
- R8: Acceptance opens again at the end of the dead cycle only if a high synchronized sample was seen after activation, the sample taken at that edge included. A pin held low throughout gives no further request.
- R9: If no high sample was seen by the end of the dead cycle, acceptance opens in the cycle after the first later high sample. Low-level sampling then resumes.
- R10: `xfer_end` is high during the dead cycle of the last block, and `chan_en` is low in the next cycle. A block count of 0 is treated as 1.
- R11: At most one of `rd_stb`, `wr_stb` and `dead_cyc` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_wr | input | 1 | Channel enable write strobe |
| req_n | input | 1 | Asynchronous request pin, active low |
| bus_brk | input | 1 | Bus-break slot granted by the arbiter |
| blk_len | input | LEN_W | Read/write pairs per block (0 means 1) |
| xfer_cnt | input | CNT_W | Blocks to run, loaded on enable (0 means 1) |
| bus_req | output | 1 | Pending request or transfer in progress |
| rd_stb | output | 1 | Read phase strobe |
| wr_stb | output | 1 | Write phase strobe |
| dead_cyc | output | 1 | Dead cycle after the last write of a block |
| xfer_end | output | 1 | High during the dead cycle of the final block |
| chan_en | output | 1 | Channel enabled |

## Verification
The bench holds the pin low through an entire block and checks that no second request appears. A design that used level acceptance would start a new block at once. It then releases and lowers the pin after the dead cycle, which catches a design that never reopens or that reopens a cycle early. The bench counts the edges from a falling pin to `bus_req`, so a missing or extra synchronizer stage shows up as a latency error. Random pin activity and random bus-break slots, with zero block lengths and counts included, are compared cycle by cycle against a bench model. That comparison exposes a wrong pair count, a doubled dead cycle, a lost enable write or a miscounted final block.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_DEAD  = 2'd3
  } phase_t;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/dreq_accept.sv
module dreq_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_hi,
  input  logic en_load,
  input  logic activate,
  input  logic dead_end,
  input  logic final_blk,
  input  logic idle,
  output logic pend,
  output logic acc_open,
  output logic chan_en
);
  logic hi_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_en  <= 1'b0;
      acc_open <= 1'b0;
      hi_seen  <= 1'b0;
      pend     <= 1'b0;
    end else if (en_load) begin
      chan_en  <= 1'b1;
      acc_open <= 1'b1;
      hi_seen  <= 1'b0;
      pend     <= 1'b0;
    end else if (activate) begin
      pend     <= 1'b0;
      acc_open <= 1'b0;
      hi_seen  <= 1'b0;
    end else begin
      if (acc_open && !pin_hi) pend <= 1'b1;
      if (!acc_open && chan_en && pin_hi) hi_seen <= 1'b1;
      if (dead_end) begin
        if (final_blk) begin
          chan_en  <= 1'b0;
          acc_open <= 1'b0;
        end else begin
          acc_open <= hi_seen | pin_hi;
        end
      end else if (idle && chan_en && !acc_open && hi_seen) begin
        acc_open <= 1'b1;
      end
    end
  end

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    activate |=> !pend);
  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !activate) |=> pend);
  // R8
  reopen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_open) |-> idle);
  // R2
  open_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_open |-> chan_en);
endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
  import dreq_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_load,
  input  logic             activate,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             dead_cyc,
  output logic             idle,
  output logic             final_blk
);
  function automatic logic [LEN_W-1:0] pairs_of(input logic [LEN_W-1:0] v);
    return (v == '0) ? LEN_W'(1) : v;
  endfunction

  function automatic logic [CNT_W-1:0] blocks_of(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  phase_t           phase;
  logic [LEN_W-1:0] pair;
  logic [LEN_W-1:0] len;
  logic [CNT_W-1:0] blk;
  logic             last_pair;

  assign last_pair = (pair == len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      pair  <= '0;
      len   <= '0;
      blk   <= '0;
    end else begin
      if (en_load) blk <= blocks_of(cnt_in);
      case (phase)
        PH_IDLE: if (activate) begin
          phase <= PH_READ;
          pair  <= '0;
          len   <= pairs_of(blk_len);
        end
        PH_READ: phase <= PH_WRITE;
        PH_WRITE: begin
          if (last_pair) phase <= PH_DEAD;
          else begin
            pair  <= pair + 1'b1;
            phase <= PH_READ;
          end
        end
        default: begin
          phase <= PH_IDLE;
          blk   <= blk - 1'b1;
        end
      endcase
    end
  end

  assign rd_stb    = (phase == PH_READ);
  assign wr_stb    = (phase == PH_WRITE);
  assign dead_cyc  = (phase == PH_DEAD);
  assign idle      = (phase == PH_IDLE);
  assign final_blk = dead_cyc && (blk == CNT_W'(1));

  // R6
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> wr_stb);
  // R6
  wr_then_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (rd_stb || dead_cyc));
  // R7
  single_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dead_cyc |=> idle);
  // R11
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stb, wr_stb, dead_cyc}));
endmodule

// File: rtl/dreq_block_seq.sv
module dreq_block_seq
  import dreq_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             req_n,
  input  logic             bus_brk,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] xfer_cnt,
  output logic             bus_req,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             dead_cyc,
  output logic             xfer_end,
  output logic             chan_en
);
  logic pin_hi;
  logic en_load;
  logic activate;
  logic pend;
  logic acc_open;
  logic idle;
  logic final_blk;

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (req_n),
    .dout (pin_hi)
  );

  assign en_load  = en_wr && !chan_en;
  assign activate = pend && bus_brk && idle;

  dreq_accept u_accept (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_hi   (pin_hi),
    .en_load  (en_load),
    .activate (activate),
    .dead_end (dead_cyc),
    .final_blk(final_blk),
    .idle     (idle),
    .pend     (pend),
    .acc_open (acc_open),
    .chan_en  (chan_en)
  );

  dreq_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_load  (en_load),
    .activate (activate),
    .blk_len  (blk_len),
    .cnt_in   (xfer_cnt),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .dead_cyc (dead_cyc),
    .idle     (idle),
    .final_blk(final_blk)
  );

  assign bus_req  = pend || !idle;
  assign xfer_end = final_blk;

  // R10
  end_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !chan_en);
  // R7
  bus_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dead_cyc |=> !bus_req);
endmodule

// File: tb/dreq_block_seq_tb.sv
module dreq_block_seq_tb;
  localparam int LEN_W = 4;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 1'b0;
  logic req_n = 1'b1;
  logic bus_brk = 1'b0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [CNT_W-1:0] xfer_cnt = '0;
  logic bus_req, rd_stb, wr_stb, dead_cyc, xfer_end, chan_en;

  int n_chk = 0;
  int n_bad = 0;
  int n_end = 0;

  always #4 clk = ~clk;

  dreq_block_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .req_n(req_n), .bus_brk(bus_brk),
    .blk_len(blk_len), .xfer_cnt(xfer_cnt), .bus_req(bus_req), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .dead_cyc(dead_cyc), .xfer_end(xfer_end), .chan_en(chan_en)
  );

  function automatic int fn_pairs(input int v);
    return (v < 1) ? 1 : v;
  endfunction
  function automatic int fn_blocks(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      if (n_bad < 20) $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // bench model, stepped from the requirements
  bit m_s1, m_s2, m_en, m_open, m_hi, m_pend;
  int m_ph, m_pair, m_len, m_blk;
  bit hi, ld, act, o_open, o_hi, o_en;
  int o_ph;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_en = 0; m_open = 0; m_hi = 0; m_pend = 0;
      m_ph = 0; m_pair = 0; m_len = 0; m_blk = 0;
    end else begin
      hi = m_s2; o_open = m_open; o_hi = m_hi; o_en = m_en; o_ph = m_ph;
      ld = en_wr && !m_en;
      act = m_pend && bus_brk && (m_ph == 0);
      m_s2 = m_s1; m_s1 = req_n;
      if (ld) begin
        m_en = 1; m_open = 1; m_hi = 0; m_pend = 0; m_blk = fn_blocks(int'(xfer_cnt));
      end else if (act) begin
        m_pend = 0; m_open = 0; m_hi = 0; m_ph = 1; m_pair = 0; m_len = fn_pairs(int'(blk_len));
      end else begin
        if (o_open && !hi) m_pend = 1;
        if (!o_open && o_en && hi) m_hi = 1;
        if (o_ph == 3) begin
          if (m_blk == 1) begin m_en = 0; m_open = 0; end
          else m_open = o_hi || hi;
        end else if (o_ph == 0 && o_en && !o_open && o_hi) m_open = 1;
      end
      if (!act) begin
        case (o_ph)
          1: m_ph = 2;
          2: if (m_pair + 1 == m_len) m_ph = 3; else begin m_pair++; m_ph = 1; end
          3: begin m_ph = 0; m_blk--; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rd_stb == (m_ph == 1), "R6 rd_stb", rd_stb, m_ph == 1);
      chk(wr_stb == (m_ph == 2), "R6 wr_stb", wr_stb, m_ph == 2);
      chk(dead_cyc == (m_ph == 3), "R7 dead_cyc", dead_cyc, m_ph == 3);
      chk(bus_req == (m_pend || m_ph != 0), "R4 bus_req", bus_req, m_pend || m_ph != 0);
      chk(chan_en == m_en, "R2 chan_en", chan_en, m_en);
      chk(xfer_end == (m_ph == 3 && m_blk == 1), "R10 xfer_end", xfer_end, m_ph == 3 && m_blk == 1);
      chk($countones({rd_stb, wr_stb, dead_cyc}) <= 1, "R11 exclusive", $countones({rd_stb, wr_stb, dead_cyc}), 1);
      if (xfer_end) n_end++;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int run, cyc, e0;
    void'($urandom(32'd4711));
    step(3);
    // R1 reset state
    @(negedge clk);
    chk({bus_req, rd_stb, wr_stb, dead_cyc, xfer_end, chan_en} == 6'b0, "R1 reset outputs",
        {bus_req, rd_stb, wr_stb, dead_cyc, xfer_end, chan_en}, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    step(2);
    chk(chan_en == 1'b0 && bus_req == 1'b0, "R1 idle after reset", chan_en, 0);

    // R2 enable with two blocks of two pairs
    en_wr = 1; xfer_cnt = 2; blk_len = 2;
    step(1); en_wr = 0;
    chk(chan_en == 1'b1, "R2 enable sets chan_en", chan_en, 1);
    step(2);

    // R3 latency through synchronizer
    req_n = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(bus_req == 1'b0, "R3 no request before third edge", bus_req, 0);
    @(posedge clk); @(negedge clk);
    chk(bus_req == 1'b1, "R3 request after third edge", bus_req, 1);

    // R4 held without bus-break; pin stays low for the R8 case
    step(6);
    chk(bus_req == 1'b1, "R4 request held", bus_req, 1);

    // R5 activation
    @(posedge clk); #2 bus_brk = 1;
    @(posedge clk); #2 bus_brk = 0;
    @(negedge clk);
    chk(rd_stb == 1'b1, "R5 read follows bus-break", rd_stb, 1);
    // R2 enable write while active is ignored
    @(posedge clk); #2 en_wr = 1; xfer_cnt = 9;
    step(1); en_wr = 0;
    step(8);

    // R8 pin held low: no new request
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(bus_req == 1'b0, "R8 no request while pin stays low", bus_req, 0);
    end

    // R9 high then low reopens acceptance
    @(posedge clk); #2 req_n = 1;
    step(6);
    req_n = 0;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk(bus_req == 1'b1, "R9 request after reopen", bus_req, 1);
    e0 = n_end;
    @(posedge clk); #2 bus_brk = 1; req_n = 1;
    step(1); bus_brk = 0;
    step(10);
    chk(n_end - e0 == 1, "R10 one end pulse after second block", n_end - e0, 1);
    chk(chan_en == 1'b0, "R10 channel disabled after count", chan_en, 0);

    // random phase
    for (int b = 0; b < 60; b++) begin
      en_wr = 1; xfer_cnt = CNT_W'($urandom_range(0, 4)); blk_len = LEN_W'($urandom_range(0, 5));
      step(1); en_wr = 0;
      cyc = 0;
      while (m_en && cyc < 600) begin
        run = $urandom_range(1, 6);
        req_n = $urandom_range(0, 1);
        for (int k = 0; k < run; k++) begin
          bus_brk = ($urandom_range(0, 1) == 1);
          en_wr = ($urandom_range(0, 19) == 0);
          xfer_cnt = CNT_W'($urandom_range(0, 7));
          blk_len = LEN_W'($urandom_range(0, 5));
          step(1);
          cyc++;
        end
      end
      en_wr = 0; bus_brk = 0; req_n = 1;
      step(3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule